// File: doc/BRIEF.md
# Two-Base-Register Call and Block Sequencer

This block carries out the four frame-management operations of a block-structured runtime in which only two base registers exist: a local pointer to the base of the current activation frame and a global pointer to the outermost frame. It keeps the stack pointer, the frame mark, the local pointer and the program counter. The stack itself lives in a single-port word memory. A command starts a procedure call, a procedure return, a block entry or a block exit. The command carries a call descriptor with a level-distance field and an offset field.

On a call, the static link is picked in one of three ways. When the level field is all ones, the static link is the global pointer. When the field is zero, it is the current local pointer. For any other value the block walks the chain of static links through memory. Each step loads the word just below the current frame base, and the number of steps equals the level distance. The entry address of the called procedure is then read from the resolved frame at the given offset. A return unwinds the frame and restores the caller's context. Block entry and exit do the same with a shorter frame that holds no return address.

Top module: `frame_seq`

## Requirements
- R1: After reset, the stack pointer equals the parameter SP_INIT, the frame mark, local pointer and program counter are zero, and busy, done and mem_en are low.
- R2: A CALL (cmd_op 0) started with stack pointer S writes the old frame mark to S, the old program counter to S+1 and the old local pointer to S+2. It then writes the static link to S+3 and leaves the frame mark at S and both the stack pointer and the local pointer at S+4. Every memory write goes to the current stack pointer.
- R3: The static link of a CALL is the glob_ptr input when cmd_lvl is all ones, and the local pointer when cmd_lvl is zero. Otherwise it is found by starting from the local pointer and replacing the pointer cmd_lvl times with the word at pointer−1. Memory read data is valid on mem_rdata the cycle after mem_en is high with mem_we low.
- R4: A CALL loads the program counter with the word at the static link plus cmd_off, with cmd_off zero-extended.
- R5: A RETURN (cmd_op 1) sets the stack pointer to the old frame mark, the frame mark to the word at the old frame mark, the program counter to the word at local pointer−3 and the local pointer to the word at local pointer−2. It writes no memory.
- R6: An ENTRY (cmd_op 2) started with stack pointer S writes the frame mark to S and the local pointer to both S+1 and S+2. It then leaves the frame mark at S and the stack pointer and local pointer at S+3. The program counter is unchanged.
- R7: An EXIT (cmd_op 3) sets the stack pointer to the old frame mark, the frame mark to the word at the old frame mark and the local pointer to the word at local pointer−1. It leaves the program counter unchanged and writes no memory.
- R8: busy rises in the cycle after a command is accepted and falls in the same cycle that done pulses high for exactly one cycle. busy stays high for 6+2·d cycles on a CALL that walks d levels (6 for the global and zero cases), 4 cycles on a RETURN and 3 cycles on an ENTRY or an EXIT.
- R9: A command presented while busy is ignored, so the result is that of the command already running. While idle with no command, all four registers hold their values and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 CALL, 1 RETURN, 2 ENTRY, 3 EXIT |
| cmd_lvl | input | LW | Level distance; all ones selects the global frame |
| cmd_off | input | OW | Offset of the procedure entry word in the resolved frame |
| glob_ptr | input | W | Base of the outermost frame |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, one cycle after a read request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | W | Stack pointer |
| fm | output | W | Frame mark |
| lp | output | W | Local pointer |
| pc | output | W | Program counter |

## Verification
A wrong link choice or a chain walk that is off by one is visible at pc and lp as soon as done pulses. It also shows up in the busy length of that same command, because each walk step costs two cycles. A frame written at the wrong offset can stay hidden through the CALL itself. It appears on the matching RETURN or EXIT, when pc, lp or fm reload from the wrong word. For that reason the stimulus nests calls and entries before unwinding them and compares the whole memory image after every command. A command leaking in while busy changes the memory image or the pointer values at the next done.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int W = 16,
  parameter int LW = 4,
  parameter int OW = 8,
  parameter logic [W-1:0] SP_INIT = 16'h0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [LW-1:0] cmd_lvl,
  input  logic [OW-1:0] cmd_off,
  input  logic [W-1:0]  glob_ptr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  sp,
  output logic [W-1:0]  fm,
  output logic [W-1:0]  lp,
  output logic [W-1:0]  pc
);

  localparam logic [1:0] OP_CALL  = 2'd0;
  localparam logic [1:0] OP_RET   = 2'd1;
  localparam logic [1:0] OP_ENTRY = 2'd2;
  localparam logic [1:0] OP_EXIT  = 2'd3;
  localparam logic [LW-1:0] LVL_GLOBAL = '1;

  typedef enum logic [4:0] {
    S_IDLE,
    C_FM, C_RA, C_DL, C_WRD, C_WWT, C_SL, C_TRD, C_TWT,
    R_FM, R_FMW, R_PCW, R_LPW,
    E_FM, E_DL, E_SL,
    X_FM, X_FMW, X_LPW
  } st_t;

  st_t st;
  logic [1:0]    op_q;
  logic [LW-1:0] lvl_q, cnt_q;
  logic [OW-1:0] off_q;
  logic [W-1:0]  ptr_q;
  logic          fin;

  assign busy = (st != S_IDLE);
  assign fin  = (st == C_TWT) || (st == R_LPW) || (st == E_SL) || (st == X_LPW);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = fm;
    case (st)
      C_FM, E_FM: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = fm; end
      C_RA:       begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = pc; end
      C_DL, E_DL, E_SL: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = lp; end
      C_SL:       begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = ptr_q; end
      C_WRD:      begin mem_en = 1'b1; mem_addr = ptr_q - 1'b1; end
      C_TRD:      begin mem_en = 1'b1; mem_addr = ptr_q + W'(off_q); end
      R_FM, X_FM: begin mem_en = 1'b1; mem_addr = fm; end
      R_FMW:      begin mem_en = 1'b1; mem_addr = lp - W'(3); end
      R_PCW:      begin mem_en = 1'b1; mem_addr = lp - W'(2); end
      X_FMW:      begin mem_en = 1'b1; mem_addr = lp - W'(1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= OP_CALL;
      lvl_q <= '0;
      cnt_q <= '0;
      off_q <= '0;
      ptr_q <= '0;
      sp    <= SP_INIT;
      fm    <= '0;
      lp    <= '0;
      pc    <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q  <= cmd_op;
          lvl_q <= cmd_lvl;
          off_q <= cmd_off;
          case (cmd_op)
            OP_CALL:  st <= C_FM;
            OP_RET:   st <= R_FM;
            OP_ENTRY: st <= E_FM;
            default:  st <= X_FM;
          endcase
        end
        C_FM: begin fm <= sp; sp <= sp + 1'b1; st <= C_RA; end
        C_RA: begin sp <= sp + 1'b1; st <= C_DL; end
        C_DL: begin
          sp    <= sp + 1'b1;
          cnt_q <= lvl_q;
          if (lvl_q == LVL_GLOBAL) begin
            ptr_q <= glob_ptr;
            st    <= C_SL;
          end else begin
            ptr_q <= lp;
            st    <= (lvl_q == '0) ? C_SL : C_WRD;
          end
        end
        C_WRD: st <= C_WWT;
        C_WWT: begin
          ptr_q <= mem_rdata;
          cnt_q <= cnt_q - 1'b1;
          st    <= (cnt_q == LW'(1)) ? C_SL : C_WRD;
        end
        C_SL:  begin sp <= sp + 1'b1; lp <= sp + 1'b1; st <= C_TRD; end
        C_TRD: st <= C_TWT;
        C_TWT: begin pc <= mem_rdata; st <= S_IDLE; end
        R_FM:  begin sp <= fm; st <= R_FMW; end
        R_FMW: begin fm <= mem_rdata; st <= R_PCW; end
        R_PCW: begin pc <= mem_rdata; st <= R_LPW; end
        R_LPW: begin lp <= mem_rdata; st <= S_IDLE; end
        E_FM:  begin fm <= sp; sp <= sp + 1'b1; st <= E_DL; end
        E_DL:  begin sp <= sp + 1'b1; st <= E_SL; end
        E_SL:  begin sp <= sp + 1'b1; lp <= sp + 1'b1; st <= S_IDLE; end
        X_FM:  begin sp <= fm; st <= X_FMW; end
        X_FMW: begin fm <= mem_rdata; st <= X_LPW; end
        X_LPW: begin lp <= mem_rdata; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_write_at_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == sp));

  p_walk_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WWT) |-> (cnt_q != '0));

  p_top_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_CALL || op_q == OP_ENTRY)) |-> (lp == sp));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> ($stable(sp) && $stable(fm) && $stable(lp) && $stable(pc)));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(op_q));

endmodule

// File: tb/frame_seq_tb.sv
`timescale 1ns/1ps
module frame_seq_tb_top;
  localparam logic [15:0] SPI = 16'h0040;
  localparam logic [15:0] GP  = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_lvl = 4'd0;
  logic [7:0] cmd_off = 8'd0;
  logic mem_en, mem_we, busy, done;
  logic [15:0] mem_addr, mem_wdata, sp, fm, lp, pc;
  logic [15:0] mem_rdata = 16'h0;

  logic [15:0] mem [256];
  logic [15:0] emem [256];
  logic ld_en = 1'b0;
  logic [7:0] ld_a = 8'd0;
  logic [15:0] ld_d = 16'd0;

  int checks = 0;
  int fails = 0;
  logic [15:0] e_sp, e_fm, e_lp, e_pc;

  always #10 clk = ~clk;

  frame_seq #(.W(16), .LW(4), .OW(8), .SP_INIT(SPI)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lvl(cmd_lvl), .cmd_off(cmd_off), .glob_ptr(GP),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .sp(sp), .fm(fm), .lp(lp), .pc(pc));

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    return emem[a[7:0]];
  endfunction

  task automatic run(input logic [1:0] op, input logic [3:0] lvl, input logic [7:0] off, input bit inj);
    logic [15:0] s, p, nsp, nfm, nlp, npc;
    int ecyc, cyc, bad;
    s = e_sp;
    ecyc = 0;
    case (op)
      2'd0: begin
        emem[s[7:0]] = e_fm;
        emem[8'(s + 16'd1)] = e_pc;
        emem[8'(s + 16'd2)] = e_lp;
        if (lvl == 4'hF) p = GP;
        else begin
          p = e_lp;
          for (int i = 0; i < int'(lvl); i++) p = rd(p - 16'd1);
        end
        emem[8'(s + 16'd3)] = p;
        e_fm = s; e_sp = s + 16'd4; e_lp = s + 16'd4;
        e_pc = rd(p + {8'h00, off});
        ecyc = (lvl == 4'h0 || lvl == 4'hF) ? 6 : 6 + 2 * int'(lvl);
      end
      2'd1: begin
        nsp = e_fm; nfm = rd(e_fm); npc = rd(e_lp - 16'd3); nlp = rd(e_lp - 16'd2);
        e_sp = nsp; e_fm = nfm; e_pc = npc; e_lp = nlp;
        ecyc = 4;
      end
      2'd2: begin
        emem[s[7:0]] = e_fm;
        emem[8'(s + 16'd1)] = e_lp;
        emem[8'(s + 16'd2)] = e_lp;
        e_fm = s; e_sp = s + 16'd3; e_lp = s + 16'd3;
        ecyc = 3;
      end
      default: begin
        nsp = e_fm; nfm = rd(e_fm); nlp = rd(e_lp - 16'd1);
        e_sp = nsp; e_fm = nfm; e_lp = nlp;
        ecyc = 3;
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_lvl = lvl; cmd_off = off;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      if (inj && cyc == 1) begin
        cmd_valid = 1'b1; cmd_op = op + 2'd1; cmd_lvl = lvl + 4'd3; cmd_off = off ^ 8'h5A;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk($sformatf("R8 busy cycles op%0d", op), 16'(cyc), 16'(ecyc));
    chk("R8 busy low with done", {15'd0, busy}, 16'd0);
    chk($sformatf("R2/R5/R6/R7 sp op%0d%s", op, inj ? " R9 inj" : ""), sp, e_sp);
    chk($sformatf("R2/R5/R6/R7 fm op%0d", op), fm, e_fm);
    chk($sformatf("R3/R5/R6/R7 lp op%0d lvl%0d", op, lvl), lp, e_lp);
    chk($sformatf("R4/R5 pc op%0d lvl%0d", op, lvl), pc, e_pc);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
    chk($sformatf("R2/R6 memory image op%0d", op), 16'(bad), 16'd0);
    @(negedge clk);
    chk("R8 done single pulse", {15'd0, done}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] h_sp, h_fm, h_lp, h_pc;
    int quiet;
    void'($urandom(32'd1977));
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_a = 8'(i); ld_d = 16'($urandom());
      emem[i] = ld_d;
    end
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", {15'd0, busy}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", sp, SPI);
    chk("R1 fm", fm, 16'd0);
    chk("R1 lp", lp, 16'd0);
    chk("R1 pc", pc, 16'd0);
    chk("R1 done/busy/mem_en", {13'd0, done, busy, mem_en}, 16'd0);
    e_sp = SPI; e_fm = 16'd0; e_lp = 16'd0; e_pc = 16'd0;

    run(2'd2, 4'd0, 8'd0, 1'b0);
    run(2'd0, 4'd0, 8'd3, 1'b0);
    run(2'd0, 4'hF, 8'd7, 1'b0);
    run(2'd0, 4'd1, 8'd1, 1'b0);
    run(2'd2, 4'd0, 8'd0, 1'b0);
    run(2'd0, 4'd2, 8'd200, 1'b0);
    run(2'd0, 4'd14, 8'd255, 1'b0);
    run(2'd1, 4'd0, 8'd0, 1'b0);
    run(2'd1, 4'd0, 8'd0, 1'b1);
    run(2'd3, 4'd0, 8'd0, 1'b0);
    run(2'd0, 4'd3, 8'd9, 1'b1);
    run(2'd2, 4'd0, 8'd0, 1'b1);
    run(2'd3, 4'd5, 8'd4, 1'b0);

    h_sp = sp; h_fm = fm; h_lp = lp; h_pc = pc;
    quiet = 0;
    repeat (6) begin
      @(negedge clk);
      if (mem_en || busy) quiet++;
    end
    chk("R9 idle no access", 16'(quiet), 16'd0);
    chk("R9 idle sp hold", sp, h_sp);
    chk("R9 idle fm hold", fm, h_fm);
    chk("R9 idle lp hold", lp, h_lp);
    chk("R9 idle pc hold", pc, h_pc);

    for (int k = 0; k < 60; k++) begin
      logic [1:0] o;
      logic [3:0] l;
      o = 2'($urandom() % 4);
      l = 4'($urandom() % 16);
      run(o, l, 8'($urandom()), ($urandom() % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule